// File: doc/BRIEF.md
# Priority reference clock selector

This block picks one of two reference clocks, a primary and a secondary, and forwards it on a single output. Both references and the select pin are sampled in a faster system clock. Each reference has its own health monitor that decides whether it is running. The forwarded clock is a registered, gated copy of the sampled reference that is currently chosen.

Selection comes from one of three sources. In automatic mode the primary wins whenever it is healthy, and the secondary is used only while the primary is down. Automatic mode always reverts to the primary once the primary is healthy again. In manual mode either a configuration bit or the external select pin decides. A strap puts the block in pin mode, where only the pin counts.

Every change of source goes through a handshake. The old clock is cut while it is low. The new clock must show two rising edges before it is let through, and it is enabled during a low phase. The status output that names the active input changes only when this handshake completes.

Top module: `refclk_sel`

## Requirements
- R1: During and right after reset, `clk_out` is 0, `src_sec` is 0 (primary) and `src_none` is 1.
- R2: In automatic mode (`pin_mode`=0, `cfg_manual`=0) with both inputs healthy, the primary is forwarded and `src_sec` is 0.
- R3: In automatic mode, when the primary is lost and the secondary is healthy, the block moves to the secondary and `src_sec` becomes 1.
- R4: In automatic mode, once the primary is healthy again, the block returns to it (`src_sec` back to 0).
- R5: With `pin_mode`=0, `cfg_manual`=1 and `cfg_pin_ctl`=0, `cfg_sec` selects the input (0 primary, 1 secondary) and `sel_pin` has no effect.
- R6: With `pin_mode`=0, `cfg_manual`=1 and `cfg_pin_ctl`=1, `sel_pin` selects the input (low primary, high secondary) and `cfg_sec` has no effect.
- R7: With `pin_mode`=1, only `sel_pin` selects the input (low primary, high secondary), and the three configuration bits have no effect.
- R8: An input is declared lost after 8 system cycles with no rising edge in its synchronized sample. It is declared healthy on its 16th rising edge after being lost. Seen at the ports, the loss shows 12 system cycles after the last driven rising edge, and health shows 3 cycles after the 16th driven rising edge. Both figures include the two-flop synchronizer and one register.
- R9: A switch cuts the old clock only while its sample is low, or once it is lost. The output never shows a high pulse shorter than the source high phase, which is at least 2 system cycles in use.
- R10: `src_sec` changes only when the handshake completes. At that moment `clk_out` is low and has been low for at least two cycles of the new source's rising-edge wait.
- R11: While both inputs are lost, `src_none` is 1 and `clk_out` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pri_clk | input | 1 | Primary reference clock |
| sec_clk | input | 1 | Secondary reference clock |
| pin_mode | input | 1 | Strap: 1 means only the select pin is used |
| cfg_manual | input | 1 | Configuration: 0 automatic, 1 manual |
| cfg_pin_ctl | input | 1 | Configuration: in manual mode, 1 hands selection to the pin |
| cfg_sec | input | 1 | Configuration: in manual register selection, 1 picks secondary |
| sel_pin | input | 1 | External select pin, low primary, high secondary |
| clk_out | output | 1 | Forwarded reference clock |
| src_sec | output | 1 | Active input: 0 primary, 1 secondary |
| src_none | output | 1 | Both references lost |

## Verification
A wrong health verdict in a monitor shows at `src_none` on a cycle-exact schedule. It also shows within a few tens of cycles as the wrong rising-edge rate on `clk_out`, because the two references run at different rates. A handover state machine that skips its wait or cuts at the wrong moment shows as a high pulse on `clk_out` that is too short. It can also show as a status flip while the output is high or has barely been low, which can be seen on the cycle of the flip. A mis-decoded selection encoding sends the other source's edge rate to `clk_out` within one measurement window after it settles.

// File: rtl/refclk_sel.sv
module refclk_sel #(
  parameter int LOSS_CYC    = 8,
  parameter int VALID_EDGES = 16,
  parameter int ARM_EDGES   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pri_clk,
  input  logic sec_clk,
  input  logic pin_mode,
  input  logic cfg_manual,
  input  logic cfg_pin_ctl,
  input  logic cfg_sec,
  input  logic sel_pin,
  output logic clk_out,
  output logic src_sec,
  output logic src_none
);

  localparam int IW = $clog2(LOSS_CYC + 1);
  localparam int GW = $clog2(VALID_EDGES + 1);
  localparam int AW = $clog2(ARM_EDGES + 1);

  typedef enum logic [1:0] {ST_ARM = 2'd0, ST_ON = 2'd1, ST_DRAIN = 2'd2} st_t;

  logic [1:0] raw, meta, samp, samp_d, rise, ok;
  logic [1:0] pin_s;
  logic       pin_q, auto_m, want_sec, no_ref;
  logic       cur, tgt, cur_samp, cur_ok, tgt_samp, tgt_rise;
  logic [AW-1:0] arm_cnt;
  st_t        st;

  assign raw = {sec_clk, pri_clk};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      meta   <= '0;
      samp   <= '0;
      samp_d <= '0;
      pin_s  <= '0;
    end else begin
      meta   <= raw;
      samp   <= meta;
      samp_d <= samp;
      pin_s  <= {pin_s[0], sel_pin};
    end

  assign rise  = samp & ~samp_d;
  assign pin_q = pin_s[1];

  // R8: per-input health monitor
  for (genvar i = 0; i < 2; i++) begin : g_mon
    logic [IW-1:0] idle;
    logic [GW-1:0] good;
    logic          okr;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        idle <= '0;
        good <= '0;
        okr  <= 1'b0;
      end else begin
        if (rise[i])
          idle <= '0;
        else if (idle != IW'(LOSS_CYC))
          idle <= idle + 1'b1;

        if (idle == IW'(LOSS_CYC) && !rise[i]) begin
          okr  <= 1'b0;
          good <= '0;
        end else if (rise[i] && !okr) begin
          good <= good + 1'b1;
          if (good == GW'(VALID_EDGES - 1))
            okr <= 1'b1;
        end
      end

    assign ok[i] = okr;
  end

  assign no_ref = ~|ok;
  assign auto_m = !pin_mode && !cfg_manual;

  // R2..R7: selection decode
  always_comb
    if (pin_mode)         want_sec = pin_q;
    else if (auto_m)      want_sec = !ok[0] && ok[1];
    else if (cfg_pin_ctl) want_sec = pin_q;
    else                  want_sec = cfg_sec;

  assign cur_samp = cur ? samp[1] : samp[0];
  assign cur_ok   = cur ? ok[1]   : ok[0];
  assign tgt_samp = tgt ? samp[1] : samp[0];
  assign tgt_rise = tgt ? rise[1] : rise[0];

  // R9, R10: cut low, wait for new edges, enable low
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st      <= ST_ARM;
      cur     <= 1'b0;
      tgt     <= 1'b0;
      arm_cnt <= '0;
    end else begin
      case (st)
        ST_ON:
          if (no_ref || want_sec != cur) st <= ST_DRAIN;
        ST_DRAIN:
          if (!cur_samp || !cur_ok) begin
            st      <= ST_ARM;
            tgt     <= want_sec;
            arm_cnt <= '0;
          end
        ST_ARM:
          if (no_ref || want_sec != tgt) begin
            tgt     <= want_sec;
            arm_cnt <= '0;
          end else if (arm_cnt != AW'(ARM_EDGES)) begin
            if (tgt_rise) arm_cnt <= arm_cnt + 1'b1;
          end else if (!tgt_samp) begin
            st  <= ST_ON;
            cur <= tgt;
          end
        default: st <= ST_ARM;
      endcase
    end

  // R11: output held low without a reference
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) clk_out <= 1'b0;
    else        clk_out <= (st != ST_ARM) && !no_ref && cur_samp;

  assign src_sec  = cur;
  assign src_none = no_ref;

endmodule

// File: rtl/refclk_sel_chk.sv
module refclk_sel_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       clk_out,
  input logic       src_sec,
  input logic       src_none,
  input logic [1:0] st,
  input logic       cur_samp,
  input logic       cur_ok,
  input logic       auto_m,
  input logic [1:0] ok
);

  localparam logic [1:0] S_ARM   = 2'd0;
  localparam logic [1:0] S_ON    = 2'd1;
  localparam logic [1:0] S_DRAIN = 2'd2;

  AST_NOREF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    src_none |=> (!clk_out && st != S_ON)); // R11

  AST_STATUS_AT_HANDOVER: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(src_sec) |-> ($past(st) == S_ARM && st == S_ON)); // R10

  AST_CUT_ONLY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DRAIN && cur_samp && cur_ok) |=> st == S_DRAIN); // R9

  AST_REVERT_TO_PRI: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_m && st == S_ON && src_sec && ok[0]) |=> st == S_DRAIN); // R4

  AST_FALLBACK_TO_SEC: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_m && st == S_ON && !src_sec && !ok[0] && ok[1]) |=> st == S_DRAIN); // R3

endmodule

bind refclk_sel refclk_sel_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .clk_out  (clk_out),
  .src_sec  (src_sec),
  .src_none (src_none),
  .st       (st),
  .cur_samp (cur_samp),
  .cur_ok   (cur_ok),
  .auto_m   (auto_m),
  .ok       (ok)
);

// File: tb/refclk_sel_tb.sv
module refclk_sel_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PRI_PER    = 4;
  localparam int SEC_PER    = 6;
  localparam int WIN        = 120;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pri_clk = 1'b0, sec_clk = 1'b0;
  logic pin_mode = 1'b0, cfg_manual = 1'b0, cfg_pin_ctl = 1'b0, cfg_sec = 1'b0, sel_pin = 1'b0;
  logic clk_out, src_sec, src_none;

  always #(CLK_PERIOD/2) clk = ~clk;

  refclk_sel dut_i (
    .clk(clk), .rst_n(rst_n), .pri_clk(pri_clk), .sec_clk(sec_clk),
    .pin_mode(pin_mode), .cfg_manual(cfg_manual), .cfg_pin_ctl(cfg_pin_ctl),
    .cfg_sec(cfg_sec), .sel_pin(sel_pin),
    .clk_out(clk_out), .src_sec(src_sec), .src_none(src_none)
  );

  int n_tests = 0, n_fail = 0;
  int steps = 0, last_rise = 0, pri_rises = 0, out_rises = 0;
  int pri_ph = 0, sec_ph = 0, hi_len = 0, lo_len = 0, runts = 0, handovers = 0;
  bit pri_run = 0, sec_run = 0, done = 0;
  logic prev_out = 1'b0, prev_sec = 1'b0;

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_near(input string req, input int act, input int exp);
    n_tests++;
    if (act < exp - 1 || act > exp + 1) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (+-1)", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int k = 0; k < n; k++) begin
      logic nv;
      @(negedge clk);
      steps++;
      if (clk_out && !prev_out) out_rises++;
      if (clk_out) begin
        hi_len++;
        lo_len = 0;
      end else begin
        if (hi_len > 0 && hi_len < 2) runts++;
        hi_len = 0;
        lo_len++;
      end
      // R10: status flips only with the output quiet after the wait
      if (rst_n && src_sec !== prev_sec) begin
        handovers++;
        n_tests++;
        if (clk_out !== 1'b0 || lo_len < 4) begin
          n_fail++;
          $display("FAIL R10: actual clk_out=%0d low_run=%0d expected clk_out=0 low_run>=4",
                   clk_out, lo_len);
        end
      end
      prev_out = clk_out;
      prev_sec = src_sec;
      pri_ph = pri_run ? (pri_ph + 1) % PRI_PER : 0;
      nv = pri_run && (pri_ph < PRI_PER/2);
      if (nv && !pri_clk) begin
        pri_rises++;
        last_rise = steps;
      end
      pri_clk = nv;
      sec_ph = sec_run ? (sec_ph + 1) % SEC_PER : 0;
      sec_clk = sec_run && (sec_ph < SEC_PER/2);
    end
  endtask

  task automatic window(input string req, input bit exp_sec, input int exp_rises);
    out_rises = 0;
    step(WIN);
    check(req, src_sec, exp_sec);
    check_near(req, out_rises, exp_rises);
  endtask

  initial begin
    step(4);
    rst_n = 1'b1;
    step(2);
    check("R1 clk_out", clk_out, 0);
    check("R1 src_sec", src_sec, 0);
    check("R1 src_none", src_none, 1);

    pri_run = 1; pri_rises = 0;
    for (int i = 0; i < 200 && src_none; i++) step(1);
    check("R8 valid edges", pri_rises, 16);
    step(40);
    window("R2 primary preferred", 1'b0, WIN / PRI_PER);

    pri_run = 0;
    for (int i = 0; i < 100 && !src_none; i++) step(1);
    check("R8 loss delay", steps - last_rise, 12);
    out_rises = 0;
    step(40);
    check("R11 no edges", out_rises, 0);
    check("R11 flag", src_none, 1);
    check("R11 low", clk_out, 0);

    sec_run = 1;
    step(200);
    window("R3 secondary alone", 1'b1, WIN / SEC_PER);

    pri_run = 1;
    step(150);
    window("R4 revert", 1'b0, WIN / PRI_PER);

    pri_run = 0;
    step(80);
    window("R3 fallback", 1'b1, WIN / SEC_PER);

    pri_run = 1;
    cfg_manual = 1; cfg_pin_ctl = 0; cfg_sec = 0; sel_pin = 1;
    step(150);
    window("R5 pin ignored", 1'b0, WIN / PRI_PER);
    cfg_sec = 1; sel_pin = 0;
    step(60);
    window("R5 register secondary", 1'b1, WIN / SEC_PER);

    cfg_pin_ctl = 1; cfg_sec = 1; sel_pin = 0;
    step(60);
    window("R6 pin low", 1'b0, WIN / PRI_PER);
    sel_pin = 1; cfg_sec = 0;
    step(60);
    window("R6 pin high", 1'b1, WIN / SEC_PER);

    pin_mode = 1; cfg_manual = 0; cfg_pin_ctl = 0; cfg_sec = 0; sel_pin = 1;
    step(60);
    window("R7 pin high over auto", 1'b1, WIN / SEC_PER);
    sel_pin = 0; cfg_manual = 1; cfg_sec = 1;
    step(60);
    window("R7 pin low over register", 1'b0, WIN / PRI_PER);

    pri_run = 0; sec_run = 0;
    step(40);
    out_rises = 0;
    step(60);
    check("R11 both lost edges", out_rises, 0);
    check("R11 both lost flag", src_none, 1);

    check("R9 runt pulses", runts, 0);
    n_tests++;
    if (handovers < 6) begin
      n_fail++;
      $display("FAIL R10: actual %0d handovers expected >= 6", handovers);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule